// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Flag Unit

This block watches eight external input pins and records, per channel, that an edge of the chosen direction has arrived. Each channel has its own polarity bit, which selects a rising or a falling edge. It also has a sticky flag bit that stays set until software clears it, and an enable bit that lets the flag take part in the shared interrupt request. The pins are treated as asynchronous. Each pin passes through a two-flop synchronizer, and an edge is found by comparing the synchronized level with its value one cycle earlier.

Software reaches the three registers through a small single-cycle register bus. A write lands on the rising clock edge where `bus_wr` is high. A read is combinational from `bus_addr`. Software may write a 1 to a flag bit, and that raises the request just as a detected edge would. Writing a 0 clears the bit, except when a qualifying edge on that channel arrives in the same cycle. The request output is the registered OR of flag AND enable over all channels.

Top module: `xint_flag_unit`

## Requirements
- R1: After reset, the flag, polarity and enable registers all read 0 and `irq` is 0.
- R2: With polarity bit i at 0, a low-to-high change on `pin_in[i]` sets flag bit i. A pin change first sampled at clock edge k shows in the flag register after edge k+2.
- R3: With polarity bit i at 1, only a high-to-low change on `pin_in[i]` sets flag bit i. The edge of the opposite direction leaves the flag at 0.
- R4: A set flag bit stays set, with no further pin activity, until software writes 0 to it or reset is applied.
- R5: One clock after any change, `irq` equals the OR over all channels of (flag bit AND enable bit). Flags with enable 0 never raise `irq`.
- R6: Writing 1 to a flag bit sets it and raises `irq` (when enabled) exactly as a pin edge would.
- R7: If a qualifying edge on channel i arrives in the same cycle that software writes 0 to flag bit i, the flag stays set. Other bits written 0 in that cycle clear.
- R8: Channel i, which handles external interrupt number 8+i, uses `pin_in[i]`, polarity bit i, enable bit i and flag bit i. An edge on one pin touches no other flag.
- R9: Register addresses are: flag register at 0, polarity register at 1, enable register at 2. Address 3 reads 0 and ignores writes. A write to any address other than 0 leaves the flag register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, taken on the rising clock edge |
| bus_addr | input | 2 | Register select (0 flags, 1 polarity, 2 enable, 3 none) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pin_in | input | 8 | Asynchronous external interrupt pins |
| irq | output | 1 | Combined registered interrupt request |

## Verification
The bench covers every channel and both polarities in both edge directions. A design that swapped the polarity sense, or wired a pin to the wrong flag bit, would set the wrong bit or set none. It checks `irq` against every enable value for several flag patterns, so a request that ignored an enable bit, or combined flags with AND instead of OR, would mismatch.

It lines up a software clear with an edge in the same cycle. A design that let the write win would lose that interrupt. It also waits long idle stretches and writes other registers, so a flag that decayed, or was disturbed by an unrelated write, would show up.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_FLAG = 2'd0,
    SEL_POL  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/xint_pin_edge.sv
module xint_pin_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_hit
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   level;

  // Synchronizer chain: bit 0 samples the pin, bit LAST is the clean level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[LAST];
    end
  end

  assign level = sync_q[LAST];

  always_comb begin
    if (fall_sel) edge_hit = prev_q & ~level;
    else          edge_hit = ~prev_q & level;
  end
endmodule

// File: rtl/xint_regs.sv
module xint_regs
  import xint_pkg::*;
#(
  parameter int unsigned N_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_CH-1:0]   wdata,
  input  logic [N_CH-1:0]   edge_v,
  output logic [N_CH-1:0]   flag_q,
  output logic [N_CH-1:0]   pol_q,
  output logic [N_CH-1:0]   en_q,
  output logic [N_CH-1:0]   rdata
);
  reg_sel_e  sel;
  logic      wr_flag;
  logic      wr_pol;
  logic      wr_en;
  logic [N_CH-1:0] flag_d;

  assign sel     = reg_sel_e'(addr);
  assign wr_flag = wr && (sel == SEL_FLAG);
  assign wr_pol  = wr && (sel == SEL_POL);
  assign wr_en   = wr && (sel == SEL_EN);

  // A detected edge always lands, even over a software clear.
  always_comb begin
    if (wr_flag) flag_d = wdata | edge_v;
    else         flag_d = flag_q | edge_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      if (wr_pol) pol_q <= wdata;
      if (wr_en)  en_q  <= wdata;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_FLAG: rdata = flag_q;
      SEL_POL:  rdata = pol_q;
      SEL_EN:   rdata = en_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/xint_flag_unit.sv
module xint_flag_unit
  import xint_pkg::*;
#(
  parameter int unsigned N_CH        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_CH-1:0]   bus_wdata,
  output logic [N_CH-1:0]   bus_rdata,
  input  logic [N_CH-1:0]   pin_in,
  output logic              irq
);
  logic [N_CH-1:0] edge_v;
  logic [N_CH-1:0] flag_q;
  logic [N_CH-1:0] pol_q;
  logic [N_CH-1:0] en_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    xint_pin_edge #(
      .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (pin_in[g]),
      .fall_sel (pol_q[g]),
      .edge_hit (edge_v[g])
    );
  end

  xint_regs #(
    .N_CH(N_CH)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .edge_v (edge_v),
    .flag_q (flag_q),
    .pol_q  (pol_q),
    .en_q   (en_q),
    .rdata  (bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(flag_q & en_q);
  end
endmodule

// File: rtl/xint_chk.sv
module xint_chk #(
  parameter int unsigned N_CH = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [1:0]      bus_addr,
  input logic [N_CH-1:0] bus_wdata,
  input logic [N_CH-1:0] edge_v,
  input logic [N_CH-1:0] flag_q,
  input logic [N_CH-1:0] en_q,
  input logic            irq
);
  // R1: registers come out of reset clear
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flag_q == '0 && en_q == '0 && !irq));

  // R4: without a flag write, no flag bit ever falls
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 2'd0) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R7: a detected edge always sets its flag, even against a clear
  a_r7_edge_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_v != '0) |=> ((flag_q & $past(edge_v)) == $past(edge_v)));

  // R6: software ones land in the flag register
  a_r6_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> ((flag_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R5: no enabled channels means no request on the next cycle
  a_r5_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq);

  // R9: writes elsewhere never set a flag that no edge set
  a_r9_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != 2'd0 && edge_v == '0) |=> (flag_q == $past(flag_q)));
endmodule

bind xint_flag_unit xint_chk #(.N_CH(N_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .edge_v    (edge_v),
  .flag_q    (flag_q),
  .en_q      (en_q),
  .irq       (irq)
);

// File: tb/sim_xint_flag_unit.sv
`timescale 1ns/1ps
module sim_xint_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'h00;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xint_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic [7:0] pats [4];
    pats[0] = 8'h01; pats[1] = 8'h80; pats[2] = 8'hA5; pats[3] = 8'h3C;

    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd_reg(2'd0, v); chk("R1 flags", v, 8'h00);
    rd_reg(2'd1, v); chk("R1 polarity", v, 8'h00);
    rd_reg(2'd2, v); chk("R1 enable", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2, R3, R8: every channel, both polarities, both edge directions
    for (int ch = 0; ch < 8; ch++) begin
      for (int pol = 0; pol < 2; pol++) begin
        wr_reg(2'd1, pol[0] ? (8'h01 << ch) : 8'h00);
        idle(4);
        wr_reg(2'd0, 8'h00);
        pin_in[ch] = 1'b1;
        idle(5);
        rd_reg(2'd0, v);
        chk(pol[0] ? "R3 rise ignored" : "R2 rise sets / R8 mapping", v,
            pol[0] ? 8'h00 : (8'h01 << ch));
        wr_reg(2'd0, 8'h00);
        pin_in[ch] = 1'b0;
        idle(5);
        rd_reg(2'd0, v);
        chk(pol[0] ? "R3 fall sets / R8 mapping" : "R2 fall ignored", v,
            pol[0] ? (8'h01 << ch) : 8'h00);
        wr_reg(2'd0, 8'h00);
      end
    end
    wr_reg(2'd1, 8'h00);

    // R2 latency: pin set before edge k, flag visible after edge k+2
    wr_reg(2'd0, 8'h00);
    @(negedge clk); pin_in[2] = 1'b1;          // sampled at edge k
    @(negedge clk); #1 bus_addr = 2'd0;
    #0.1 chk("R2 latency not yet (k)", bus_rdata, 8'h00);
    @(negedge clk); #1 chk("R2 latency not yet (k+1)", bus_rdata, 8'h00);
    @(negedge clk); #1 chk("R2 latency after k+2", bus_rdata, 8'h04);

    // R4 sticky over a long idle stretch and unrelated writes (R9)
    pin_in[2] = 1'b0;
    idle(40);
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd3, 8'hFF);
    rd_reg(2'd0, v); chk("R4 sticky / R9 other writes", v, 8'h04);
    rd_reg(2'd3, v); chk("R9 addr 3 reads 0", v, 8'h00);
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, v); chk("R4 software clear", v, 8'h00);

    // R5, R6: software flags against every enable value
    foreach (pats[p]) begin
      wr_reg(2'd0, pats[p]);
      for (int e = 0; e < 256; e++) begin
        wr_reg(2'd2, e[7:0]);
        idle(1);
        chk("R5 R6 irq = OR(flag & en)", {7'b0, irq},
            {7'b0, |(pats[p] & e[7:0])});
      end
      wr_reg(2'd2, 8'h00);
      wr_reg(2'd0, 8'h00);
    end

    // R5: edge-set flag raises irq once enabled
    wr_reg(2'd2, 8'h10);
    pin_in[4] = 1'b1;
    idle(6);
    chk("R5 edge flag raises irq", {7'b0, irq}, 8'h01);
    wr_reg(2'd0, 8'h00);
    idle(1);
    chk("R5 irq drops after clear", {7'b0, irq}, 8'h00);
    pin_in[4] = 1'b0;
    wr_reg(2'd2, 8'h00);
    idle(4);
    wr_reg(2'd0, 8'h00);

    // R7: a clear landing on the edge-detect cycle loses to the edge
    for (int ch = 0; ch < 8; ch += 3) begin
      wr_reg(2'd0, 8'hFF);
      @(negedge clk); pin_in[ch] = 1'b1;       // sampled at edge k
      @(negedge clk);                           // after edge k
      @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h00;
      @(negedge clk); bus_wr = 1'b0;           // write landed at edge k+2
      rd_reg(2'd0, v);
      chk("R7 edge beats clear", v, 8'h01 << ch);
      pin_in[ch] = 1'b0;
      idle(4);
      wr_reg(2'd0, 8'h00);
    end

    // R1: reset mid-run clears everything
    wr_reg(2'd0, 8'h5A); wr_reg(2'd1, 8'hC3); wr_reg(2'd2, 8'hFF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_reg(2'd0, v); chk("R1 flags after reset", v, 8'h00);
    rd_reg(2'd1, v); chk("R1 polarity after reset", v, 8'h00);
    rd_reg(2'd2, v); chk("R1 enable after reset", v, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule